// File: doc/BRIEF.md
# Lane-Partitioned Integer Add/Subtract Unit

This block adds or subtracts two 64-bit operands as a set of independent integer lanes. A 3-bit operation code picks the lane layout and the direction. The layout is four 16-bit lanes or two 32-bit lanes across the full word. In single-word form, only the low 32 bits of each operand are used, either as two 16-bit lanes or as one 32-bit lane. Every lane wraps modulo its own width. A carry or borrow never leaves its lane.

The arithmetic is one ripple of 16-bit segment adders. At a lane boundary the carry link between two segments is broken, and the segment above the boundary takes the operation's own carry-in. Subtraction is the sum of `rs1`, the inverted `rs2` and a carry-in of one. It therefore gives `rs1 - rs2` in two's complement in every lane. The result and its valid flag are registered, so they appear one clock after the input strobe.

Top module: `lane_addsub`

## Requirements
- R1: With op = 3'b000 (add) or 3'b100 (subtract), the word is split into four 16-bit lanes. No carry or borrow passes between them: 0x5566FFFF5566FFFF + 0xAA990001AA990001 gives 0xFFFF0000FFFF0000.
- R2: With op = 3'b010 or 3'b110, the word is split into two 32-bit lanes. Carries cross bit 16 but not bit 32: the same operands give 0x0000000000000000.
- R3: With op bit 0 set (3'b001, 3'b011, 3'b101, 3'b111), only bits [31:0] of each operand are used, and result bits [63:32] are zero.
- R4: Each lane result wraps modulo 2^lane-width. The unit has no saturation and no overflow output.
- R5: Op bit 2 set selects subtraction. Each lane computes rs1 minus rs2 and wraps to two's complement when rs1 < rs2. For example, 0x4321 - 0x5432 in a 16-bit lane gives 0xEEEF.
- R6: Adding rs2 = 0, or subtracting rs2 = 0, returns rs1 in every op code. In the single-word forms the upper half of the result is zero.
- R7: out_valid is high in exactly the cycle after a cycle with in_valid high. The result of that input appears in the same cycle.
- R8: While in_valid is low, the result register holds its last value, whatever op, rs1 and rs2 do.
- R9: A synchronous active-high reset clears out_valid and result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op code are presented this cycle |
| op | input | 3 | {subtract, 32-bit lanes, single word} |
| rs1 | input | 64 | First operand (minuend for subtraction) |
| rs2 | input | 64 | Second operand (subtrahend for subtraction) |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered lane-wise result |

## Verification
The clocked properties assume that in_valid, op, rs1 and rs2 carry known values in every cycle after reset. They also assume that in_valid is low while reset is held, so that the first cycle after reset follows a quiet input. The bench changes every input only on the falling edge. It holds in_valid low through reset and returns it low after each single-cycle strobe, so each input is seen at exactly one rising edge. The zero-operand property is limited to the full-word forms, because the single-word forms deliberately discard the upper half of rs1.

// File: rtl/lane_addsub_pkg.sv
package lane_addsub_pkg;

    parameter int unsigned DATA_W = 64;
    parameter int unsigned SEG_W  = 16;
    parameter int unsigned WIDE_W = 32;

    localparam int unsigned NSEG       = DATA_W / SEG_W;
    localparam int unsigned HALF_W     = DATA_W / 2;
    localparam int unsigned SEG_PER_WL = WIDE_W / SEG_W;

    // Bit order matches the op port: [2] subtract, [1] wide lanes, [0] single word
    typedef struct packed {
        logic sub;
        logic wide;
        logic single;
    } op_t;

    typedef struct packed {
        logic [NSEG-1:0] lane_start;  // segment k begins a new lane
        logic            sub;
        logic            single;
    } seg_ctl_t;

    function automatic logic [NSEG-1:0] starts_for(input logic wide);
        logic [NSEG-1:0] s;
        for (int k = 0; k < NSEG; k++) begin
            s[k] = wide ? ((k % SEG_PER_WL) == 0) : 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/lane_ctl.sv
module lane_ctl
    import lane_addsub_pkg::*;
(
    input  op_t      op_i,
    output seg_ctl_t ctl_o
);

    always_comb begin
        ctl_o.lane_start = starts_for(op_i.wide);
        ctl_o.sub        = op_i.sub;
        ctl_o.single     = op_i.single;
    end

endmodule

// File: rtl/seg_chain.sv
module seg_chain
    import lane_addsub_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  seg_ctl_t          ctl_i,
    output logic [DATA_W-1:0] sum_o
);

    logic [NSEG-1:0] cin;
    logic [NSEG-1:0] cout;

    genvar k;
    generate
        for (k = 0; k < NSEG; k++) begin : g_seg
            logic [SEG_W-1:0] a_seg;
            logic [SEG_W-1:0] b_eff;
            logic [SEG_W:0]   wide_sum;

            assign a_seg = a_i[k*SEG_W +: SEG_W];
            assign b_eff = ctl_i.sub ? ~b_i[k*SEG_W +: SEG_W] : b_i[k*SEG_W +: SEG_W];

            if (k == 0) begin : g_first
                assign cin[k] = ctl_i.sub;
            end else begin : g_link
                assign cin[k] = ctl_i.lane_start[k] ? ctl_i.sub : cout[k-1];
            end

            assign wide_sum = {1'b0, a_seg} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin[k]};
            assign cout[k]  = wide_sum[SEG_W];
            assign sum_o[k*SEG_W +: SEG_W] = wide_sum[SEG_W-1:0];
        end
    endgenerate

    // Narrow-lane layout: each segment must match its own lane arithmetic
    always_comb begin
        if (&ctl_i.lane_start) begin
            for (int j = 0; j < NSEG; j++) begin
                AST_SEG_ISOLATED: assert (sum_o[j*SEG_W +: SEG_W] ==
                    (ctl_i.sub ? a_i[j*SEG_W +: SEG_W] - b_i[j*SEG_W +: SEG_W]
                               : a_i[j*SEG_W +: SEG_W] + b_i[j*SEG_W +: SEG_W])); // R1
            end
        end
    end

endmodule

// File: rtl/lane_addsub.sv
module lane_addsub
    import lane_addsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] rs1,
    input  logic [DATA_W-1:0] rs2,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    op_t               op_s;
    seg_ctl_t          ctl;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W-1:0] sum;

    assign op_s = op_t'(op);

    lane_ctl u_ctl (
        .op_i  (op_s),
        .ctl_o (ctl)
    );

    // Single-word forms see only the low half of each operand
    always_comb begin
        a_m = rs1;
        b_m = rs2;
        if (ctl.single) begin
            a_m[DATA_W-1:HALF_W] = '0;
            b_m[DATA_W-1:HALF_W] = '0;
        end
    end

    seg_chain u_chain (
        .a_i   (a_m),
        .b_i   (b_m),
        .ctl_i (ctl),
        .sum_o (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sum;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[0]) |=> (result[DATA_W-1:HALF_W] == '0)); // R3
    AST_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op[0] && (rs2 == '0)) |=> (result == $past(rs1))); // R6

endmodule

// File: tb/sim_lane_addsub.sv
`timescale 1ns/1ps
module sim_lane_addsub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lane_addsub u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .rs1(rs1), .rs2(rs2), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic [63:0] x;
        logic [63:0] y;
        x = a; y = b; r = '0;
        if (o[0]) begin x[63:32] = '0; y[63:32] = '0; end
        if (o[1]) begin
            for (int l = 0; l < 2; l++) begin
                logic [31:0] p, q;
                p = x[l*32 +: 32]; q = y[l*32 +: 32];
                r[l*32 +: 32] = o[2] ? p - q : p + q;
            end
        end else begin
            for (int l = 0; l < 4; l++) begin
                logic [15:0] p, q;
                p = x[l*16 +: 16]; q = y[l*16 +: 16];
                r[l*16 +: 16] = o[2] ? p - q : p + q;
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobe; samples on the falling edge after the capturing rising edge
    task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] res, output logic v);
        @(negedge clk);
        in_valid = 1'b1; op = o; rs1 = a; rs2 = b;
        @(negedge clk);
        in_valid = 1'b0;
        res = result; v = out_valid;
    endtask

    task automatic t_reset();
        chk("R9 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R9 result after reset", result, 64'd0);
    endtask

    task automatic t_narrow_cut();
        logic [63:0] r; logic v;
        issue(3'b000, 64'h5566FFFF5566FFFF, 64'hAA990001AA990001, r, v);
        chk("R1 narrow carry cut", r, 64'hFFFF0000FFFF0000);
        issue(3'b000, 64'h3F804135408040A0, 64'h3F80CEBA4182DF5E, r, v);
        chk("R1 narrow lanes sum", r, 64'h7F000FEF82021FFE);
        issue(3'b100, 64'h0001000000000000, 64'h0000000000000001, r, v);
        chk("R1 narrow borrow cut", r, 64'h000100000000FFFF);
    endtask

    task automatic t_wide_lanes();
        logic [63:0] r; logic v;
        issue(3'b010, 64'h5566FFFF5566FFFF, 64'hAA990001AA990001, r, v);
        chk("R2 wide carry crosses 16 not 32", r, 64'h0000000000000000);
        issue(3'b010, 64'h3F804135408040A0, 64'h3F80CEBA4182DF5E, r, v);
        chk("R2 wide lanes sum", r, 64'h7F010FEF82031FFE);
        issue(3'b110, 64'h0000000000000005, 64'h0000000100000006, r, v);
        chk("R2 wide borrow stays in lane", r, 64'hFFFFFFFFFFFFFFFF);
    endtask

    task automatic t_single();
        logic [63:0] r; logic v;
        issue(3'b001, 64'hFFFFFFFF5566FFFF, 64'h12345678AA990001, r, v);
        chk("R3 single narrow", r, 64'h00000000FFFF0000);
        issue(3'b011, 64'hFFFFFFFF5566FFFF, 64'h12345678AA990001, r, v);
        chk("R3 single wide", r, 64'h0000000000000000);
        issue(3'b011, 64'hDEADBEEF00000001, 64'h0000000100000002, r, v);
        chk("R3 single upper ignored", r, 64'h0000000000000003);
    endtask

    task automatic t_wrap();
        logic [63:0] r; logic v;
        issue(3'b000, 64'hFFFFFFFF80007FFF, 64'h0001FFFF80000001, r, v);
        chk("R4 narrow wrap", r, 64'h0000FFFE00008000);
        issue(3'b010, 64'hFFFFFFFF7FFFFFFF, 64'h0000000100000001, r, v);
        chk("R4 wide wrap", r, 64'h0000000080000000);
    endtask

    task automatic t_sub_order();
        logic [63:0] r; logic v;
        issue(3'b101, 64'h0000000043217BCD, 64'h0000000054327DF2, r, v);
        chk("R5 narrow rs1<rs2", r, 64'h00000000EEEFFDDB);
        issue(3'b101, 64'h0000000054327DF2, 64'h0000000043217BCD, r, v);
        chk("R5 narrow rs1>rs2", r, 64'h0000000011110225);
        issue(3'b111, 64'h0000000043217BCD, 64'h0000000054327DF2, r, v);
        chk("R5 single wide rs1<rs2", r, 64'h00000000EEEEFDDB);
    endtask

    task automatic t_zero();
        logic [63:0] r; logic v; logic [63:0] a;
        a = 64'h9ABC_DEF0_1357_2468;
        for (int o = 0; o < 8; o++) begin
            issue(3'(o), a, 64'd0, r, v);
            chk($sformatf("R6 zero rs2 op=%0d", o), r, o[0] ? {32'd0, a[31:0]} : a);
        end
    endtask

    task automatic t_valid();
        logic [63:0] r; logic v;
        issue(3'b000, 64'd1, 64'd2, r, v);
        chk("R7 out_valid one cycle after strobe", {63'd0, v}, 64'd1);
        chk("R7 result with valid", r, 64'd3);
        @(negedge clk);
        chk("R7 out_valid drops", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] r; logic v;
        issue(3'b010, 64'h1111111122222222, 64'h0000000100000001, r, v);
        op = 3'b111; rs1 = 64'hFFFFFFFFFFFFFFFF; rs2 = 64'h0123456789ABCDEF;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            rs1 = rs1 - 64'd7;
            chk("R8 result held without strobe", result, 64'h1111111222222223);
        end
    endtask

    task automatic t_random();
        logic [63:0] r; logic v; logic [63:0] a; logic [63:0] b;
        for (int n = 0; n < 64; n++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            issue(3'(n % 8), a, b, r, v);
            chk($sformatf("R1 R2 R3 R4 R5 random op=%0d", n % 8), r, model(3'(n % 8), a, b));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_narrow_cut();
        t_wide_lanes();
        t_single();
        t_wrap();
        t_sub_order();
        t_zero();
        t_valid();
        t_hold();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule